// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sequences exception entry and return for a small processor core. It supports two request sources, a normal interrupt and a fast interrupt. When it accepts a request, it saves the interrupted program counter and the current status word into a link register and a saved-status register. Each exception mode has its own copy of these two registers. In the same step it sets the mode field of the status word, sets the interrupt mask bits and redirects fetch to a fixed vector. A one-cycle flush pulse goes to the pipeline.

On a return request it reloads the status word from the saved copy of the current mode, which also brings back the previous mode and masks. Fetch is redirected to the link value minus a fixed pipeline offset. Because each mode keeps its own saved state, a fast interrupt can preempt a normal-interrupt handler. The two levels then unwind in reverse order.

The datapath writes the condition flags through a write strobe. The banked link and saved-status values of the current mode are readable at all times. All pins are plain control and status signals with no handshake. Every output is a register that updates on the clock edge that samples the request.

Top module: `exc_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, the status word is 0 (base mode, no masks, flags 0), `next_pc_o` is 0, and `flush_o` and `ret_err_o` are 0.
- R2: Accepting a fast interrupt sets `next_pc_o` to `FIQ_VEC` (0x1C) and accepting a normal interrupt sets it to `IRQ_VEC` (0x18). Each entry raises `flush_o` for exactly one cycle.
- R3: On entry, `cur_pc` is stored in the link register of the target mode. That value then reads back on `link_o` while the target mode is current.
- R4: On entry, the status word in force before entry is stored in the saved-status register of the target mode. It reads back on `spsr_o` while that mode is current.
- R5: The status word is laid out as mode in bits [1:0] (0 base, 1 normal interrupt, 2 fast interrupt), normal-interrupt mask in bit 2, fast-interrupt mask in bit 3 and flags in bits [7:4]. Fast-interrupt entry sets mode 2 and both masks. Normal-interrupt entry sets mode 1 and bit 2 and leaves bit 3 unchanged. Entry leaves the flags unchanged.
- R6: The fast interrupt wins when both requests are acceptable. A request whose mask bit is set is not taken: there is no flush and the status word does not change.
- R7: A return while not in base mode sets `next_pc_o` to the current link value minus 4. It restores the whole status word from the current saved-status register and raises `flush_o` for one cycle.
- R8: A fast interrupt preempts a normal-interrupt handler. The two returns then restore the normal-interrupt state first and the base state second, each using its own bank.
- R9: When a return and an acceptable request arrive in the same cycle, the return is performed. The request is considered on the next cycle against the restored masks.
- R10: A return request in base mode changes nothing and raises `ret_err_o` for one cycle.
- R11: `flag_we` loads `flags_i` into bits [7:4] unless an entry, a return or any return request happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Normal interrupt request, level |
| fiq_req | input | 1 | Fast interrupt request, level |
| ret_req | input | 1 | Return-from-exception strobe |
| cur_pc | input | PC_W | Program counter of the instruction being interrupted |
| flag_we | input | 1 | Condition flag write strobe |
| flags_i | input | FLAG_W | Condition flags from the datapath |
| next_pc_o | output | PC_W | Redirect target, valid while flush_o is high |
| flush_o | output | 1 | One-cycle pipeline flush on entry or return |
| stat_o | output | FLAG_W+4 | Current status word |
| mode_o | output | 2 | Current mode field |
| link_o | output | PC_W | Link register of the current mode (0 in base mode) |
| spsr_o | output | FLAG_W+4 | Saved status of the current mode (0 in base mode) |
| ret_err_o | output | 1 | Return was requested in base mode |

## Verification
Every result is registered once. A request or return strobe that is driven before a rising edge shows on `flush_o`, `next_pc_o`, the status word, the bank read ports and `ret_err_o` at the next falling edge. A request that is blocked by a same-cycle return shows one cycle later. The bench drives stimulus on falling edges. It queues the expected redirect target and status word at the same edge. A monitor pops one entry at every falling edge where `flush_o` is high, so any extra flush, missing flush or flush that lasts too long is reported. Bank contents, masked requests and error pulses are checked directly at the falling edge after the strobe.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned NUM_EXC  = 2;
  localparam int unsigned MODE_LSB = 0;
  localparam int unsigned IMSK_BIT = 2;
  localparam int unsigned FMSK_BIT = 3;
  localparam int unsigned FLAG_LSB = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_BASE = 2'd0,
    MODE_IRQ  = 2'd1,
    MODE_FIQ  = 2'd2
  } mode_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter (
  input  logic irq_req,
  input  logic fiq_req,
  input  logic irq_masked,
  input  logic fiq_masked,
  input  logic hold,
  output logic take_irq,
  output logic take_fiq
);
  logic fiq_ok, irq_ok;

  assign fiq_ok   = fiq_req && !fiq_masked;
  assign irq_ok   = irq_req && !irq_masked;
  // the fast source outranks the normal one; a return in flight holds both
  assign take_fiq = !hold && fiq_ok;
  assign take_irq = !hold && irq_ok && !fiq_ok;
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned ST_W   = 8,
  parameter int unsigned NBANK  = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [ST_W-1:0]  wr_st,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [PC_W-1:0]  rd_pc,
  output logic [ST_W-1:0]  rd_st
);
  logic [PC_W-1:0] lr_q [NBANK+1];
  logic [ST_W-1:0] sv_q [NBANK+1];

  // slot 0 stands for base mode, which owns no bank
  assign lr_q[0] = '0;
  assign sv_q[0] = '0;

  for (genvar b = 1; b <= NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lr_q[b] <= '0;
        sv_q[b] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(b))) begin
        lr_q[b] <= wr_pc;
        sv_q[b] <= wr_st;
      end
    end
  end

  always_comb begin
    rd_pc = '0;
    rd_st = '0;
    for (int i = 1; i <= NBANK; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        rd_pc = lr_q[i];
        rd_st = sv_q[i];
      end
    end
  end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
#(
  parameter int unsigned     PC_W    = 32,
  parameter int unsigned     FLAG_W  = 4,
  parameter logic [PC_W-1:0] IRQ_VEC = 32'h18,
  parameter logic [PC_W-1:0] FIQ_VEC = 32'h1C,
  parameter int unsigned     RET_OFS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   irq_req,
  input  logic                   fiq_req,
  input  logic                   ret_req,
  input  logic [PC_W-1:0]        cur_pc,
  input  logic                   flag_we,
  input  logic [FLAG_W-1:0]      flags_i,
  output logic [PC_W-1:0]        next_pc_o,
  output logic                   flush_o,
  output logic [FLAG_W+3:0]      stat_o,
  output logic [1:0]             mode_o,
  output logic [PC_W-1:0]        link_o,
  output logic [FLAG_W+3:0]      spsr_o,
  output logic                   ret_err_o
);
  localparam int unsigned ST_W = FLAG_W + FLAG_LSB;

  logic [ST_W-1:0]   stat_q, stat_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic              flush_q, err_q;
  logic [MODE_W-1:0] mode_cur, tgt_mode;
  logic              in_exc, do_ret, bad_ret;
  logic              take_irq, take_fiq, take_any;
  logic [PC_W-1:0]   bank_pc;
  logic [ST_W-1:0]   bank_st;

  assign mode_cur = stat_q[MODE_LSB +: MODE_W];
  assign in_exc   = (mode_cur != MODE_BASE);
  assign do_ret   = ret_req && in_exc;
  assign bad_ret  = ret_req && !in_exc;
  assign take_any = take_irq || take_fiq;
  assign tgt_mode = take_fiq ? MODE_FIQ : MODE_IRQ;

  exc_arbiter u_arb (
    .irq_req    (irq_req),
    .fiq_req    (fiq_req),
    .irq_masked (stat_q[IMSK_BIT]),
    .fiq_masked (stat_q[FMSK_BIT]),
    .hold       (ret_req),
    .take_irq   (take_irq),
    .take_fiq   (take_fiq)
  );

  exc_bank #(
    .PC_W  (PC_W),
    .ST_W  (ST_W),
    .NBANK (NUM_EXC),
    .SEL_W (MODE_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (take_any),
    .wr_sel (tgt_mode),
    .wr_pc  (cur_pc),
    .wr_st  (stat_q),
    .rd_sel (mode_cur),
    .rd_pc  (bank_pc),
    .rd_st  (bank_st)
  );

  always_comb begin
    stat_d = stat_q;
    pc_d   = pc_q;
    if (do_ret) begin
      stat_d = bank_st;
      pc_d   = bank_pc - PC_W'(RET_OFS);
    end else if (take_fiq) begin
      stat_d[MODE_LSB +: MODE_W] = MODE_FIQ;
      stat_d[IMSK_BIT]           = 1'b1;
      stat_d[FMSK_BIT]           = 1'b1;
      pc_d                       = FIQ_VEC;
    end else if (take_irq) begin
      stat_d[MODE_LSB +: MODE_W] = MODE_IRQ;
      stat_d[IMSK_BIT]           = 1'b1;
      pc_d                       = IRQ_VEC;
    end else if (flag_we && !ret_req) begin
      stat_d[FLAG_LSB +: FLAG_W] = flags_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      pc_q    <= '0;
      flush_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      pc_q    <= pc_d;
      flush_q <= do_ret || take_any;
      err_q   <= bad_ret;
    end
  end

  assign next_pc_o = pc_q;
  assign flush_o   = flush_q;
  assign stat_o    = stat_q;
  assign mode_o    = mode_cur;
  assign link_o    = bank_pc;
  assign spsr_o    = bank_st;
  assign ret_err_o = err_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int unsigned     PC_W    = 32,
  parameter int unsigned     FLAG_W  = 4,
  parameter logic [PC_W-1:0] IRQ_VEC = 32'h18,
  parameter logic [PC_W-1:0] FIQ_VEC = 32'h1C,
  parameter int unsigned     RET_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_req,
  input logic              fiq_req,
  input logic              ret_req,
  input logic [PC_W-1:0]   cur_pc,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              flush_o,
  input logic [FLAG_W+3:0] stat_o,
  input logic [1:0]        mode_o,
  input logic [PC_W-1:0]   link_o,
  input logic [FLAG_W+3:0] spsr_o,
  input logic              ret_err_o
);
  localparam logic [PC_W-1:0] OFS = PC_W'(RET_OFS);

  p_fiq_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_req && !stat_o[3] && !ret_req) |=> (flush_o && next_pc_o == FIQ_VEC && mode_o == 2'd2));

  p_irq_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !fiq_req && !stat_o[2] && !ret_req)
      |=> (flush_o && next_pc_o == IRQ_VEC && mode_o == 2'd1 && stat_o[2]));

  p_link_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_req && !stat_o[3] && !ret_req) |=> (link_o == $past(cur_pc) && spsr_o == $past(stat_o)));

  p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && mode_o != 2'd0)
      |=> (flush_o && next_pc_o == $past(link_o) - OFS && stat_o == $past(spsr_o)));

  p_bad_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && mode_o == 2'd0) |=> (ret_err_o && !flush_o && $stable(stat_o)));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_req && (!fiq_req || stat_o[3]) && (!irq_req || stat_o[2])) |=> !flush_o);
endmodule

bind exc_seq_ctrl exc_seq_chk #(
  .PC_W    (PC_W),
  .FLAG_W  (FLAG_W),
  .IRQ_VEC (IRQ_VEC),
  .FIQ_VEC (FIQ_VEC),
  .RET_OFS (RET_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .fiq_req   (fiq_req),
  .ret_req   (ret_req),
  .cur_pc    (cur_pc),
  .next_pc_o (next_pc_o),
  .flush_o   (flush_o),
  .stat_o    (stat_o),
  .mode_o    (mode_o),
  .link_o    (link_o),
  .spsr_o    (spsr_o),
  .ret_err_o (ret_err_o)
);

// File: tb/tb_exc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_exc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, irq_req, fiq_req, ret_req, flag_we;
  logic [31:0] cur_pc;
  logic [3:0]  flags_i;
  logic [31:0] next_pc_o, link_o;
  logic        flush_o, ret_err_o;
  logic [7:0]  stat_o, spsr_o;
  logic [1:0]  mode_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct packed { logic [31:0] pc; logic [7:0] st; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  exc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fiq_req(fiq_req),
    .ret_req(ret_req), .cur_pc(cur_pc), .flag_we(flag_we), .flags_i(flags_i),
    .next_pc_o(next_pc_o), .flush_o(flush_o), .stat_o(stat_o), .mode_o(mode_o),
    .link_o(link_o), .spsr_o(spsr_o), .ret_err_o(ret_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] pc, input logic [7:0] st);
    sb.push_back('{pc: pc, st: st});
  endtask

  // monitor: every flush cycle must match the oldest expected redirect (R2, R7)
  always @(negedge clk) begin
    if (rst_n && flush_o) begin
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2/R7 unexpected flush actual pc=%h st=%h expected=none", next_pc_o, stat_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R2_R7 redirect pc", next_pc_o, e.pc);
        chk("R5_R7 status after flush", {24'd0, stat_o}, {24'd0, e.st});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_req = 0; fiq_req = 0; ret_req = 0; flag_we = 0;
    cur_pc = 0; flags_i = 0;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 status", {24'd0, stat_o}, 32'h0);
    chk("R1 next_pc", next_pc_o, 32'h0);
    chk("R1 flush", {31'd0, flush_o}, 32'h0);
    chk("R1 ret_err", {31'd0, ret_err_o}, 32'h0);
    rst_n = 1;
    cyc();

    // R10 return in base mode
    ret_req = 1; cyc(); ret_req = 0;
    chk("R10 ret_err pulse", {31'd0, ret_err_o}, 32'h1);
    chk("R10 status unchanged", {24'd0, stat_o}, 32'h0);
    cyc();
    chk("R10 ret_err one cycle", {31'd0, ret_err_o}, 32'h0);

    // R11 flag write
    flags_i = 4'hA; flag_we = 1; cyc(); flag_we = 0;
    chk("R11 flag write", {24'd0, stat_o}, 32'hA0);
    flags_i = 4'h3; flag_we = 1; ret_req = 1; cyc(); flag_we = 0; ret_req = 0;
    chk("R11 flag write blocked by return request", {24'd0, stat_o}, 32'hA0);

    // R3 R4 R5 normal interrupt entry
    cur_pc = 32'h100; irq_req = 1; push(32'h18, 8'hA5); cyc();
    chk("R3 link irq", link_o, 32'h100);
    chk("R4 saved status irq", {24'd0, spsr_o}, 32'hA0);
    cyc(); irq_req = 0;   // held request is masked: monitor flags any extra flush (R6)
    chk("R6 irq masked in handler", {24'd0, stat_o}, 32'hA5);

    flags_i = 4'h5; flag_we = 1; cyc(); flag_we = 0;
    chk("R11 flag write in handler", {24'd0, stat_o}, 32'h55);

    // R8 fast interrupt preempts normal handler
    cur_pc = 32'h200; fiq_req = 1; push(32'h1C, 8'h5E); cyc(); fiq_req = 0;
    chk("R3 link fiq", link_o, 32'h200);
    chk("R4 saved status fiq", {24'd0, spsr_o}, 32'h55);
    irq_req = 1; cyc(); irq_req = 0;
    chk("R6 irq masked in fiq", {24'd0, stat_o}, 32'h5E);

    ret_req = 1; push(32'h1FC, 8'h55); cyc(); ret_req = 0;
    chk("R8 irq bank visible after return", link_o, 32'h100);
    ret_req = 1; push(32'hFC, 8'hA0); cyc(); ret_req = 0;
    chk("R8 back in base", {30'd0, mode_o}, 32'h0);

    // R6 priority, then pending irq taken after return
    cur_pc = 32'h500; irq_req = 1; fiq_req = 1; push(32'h1C, 8'hAE); cyc(); fiq_req = 0;
    chk("R6 fiq wins", {30'd0, mode_o}, 32'h2);
    chk("R6 link", link_o, 32'h500);
    ret_req = 1; push(32'h4FC, 8'hA0); cyc(); ret_req = 0;
    push(32'h18, 8'hA5); cyc(); irq_req = 0;
    chk("R6 pending irq taken", {30'd0, mode_o}, 32'h1);
    ret_req = 1; push(32'h4FC, 8'hA0); cyc(); ret_req = 0;

    // R9 return and request together
    cur_pc = 32'h300; irq_req = 1; push(32'h18, 8'hA5); cyc(); irq_req = 0;
    cur_pc = 32'h400; fiq_req = 1; ret_req = 1;
    push(32'h2FC, 8'hA0); push(32'h1C, 8'hAE);
    cyc(); ret_req = 0;
    chk("R9 return first", {30'd0, mode_o}, 32'h0);
    cyc(); fiq_req = 0;
    chk("R9 fiq next cycle", {30'd0, mode_o}, 32'h2);
    chk("R9 fiq link", link_o, 32'h400);
    chk("R9 fiq saved status", {24'd0, spsr_o}, 32'hA0);
    ret_req = 1; push(32'h3FC, 8'hA0); cyc(); ret_req = 0;
    repeat (3) cyc();
    chk("R2 all expected flushes seen", sb.size(), 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule